// File: doc/BRIEF.md
# Activate Spacing Guard

This block sits ahead of a DDR3-class command scheduler and answers one question every controller clock: may a new row ACTIVATE issue now? Two spacing limits apply together. One is a minimum number of cycles between any two consecutive activates. The other is a rolling window in which no more than four activates may land. Both limits depend on the selected page size (1KB or 2KB) and the selected speed grade. Each is the larger of a cycle floor and a nanosecond minimum, rounded up to whole clocks of period `TCK_PS` picoseconds.

The scheduler raises `act_req` when it wants to activate. The block answers with `act_grant` in the same cycle. The scheduler then reports every activate it actually drives through `act_issued`, and the block keeps its history from that stream. The handshake works like valid/ready: `act_req` is the valid and `act_grant` is the ready. A request that sees `act_grant` low must be held or retried later, and no activate may be issued in that cycle. If an activate is reported while the spacing rules forbid it, a sticky `violation` flag is raised. `page_2k` and `speed_sel` are plain static controls.

Top module: `act_spacing_guard`

## Requirements
- R1: The pairwise activate gap, in cycles, is max(GAP_FLOOR_CK, ceil(ps / TCK_PS)). The ps value comes from the setting: 7500 for 1KB and 10000 for 2KB at speed_sel 0 (800 grade) and 1 (1066 grade); 6000 for 1KB and 7500 for 2KB at speed_sel 2 (1333 grade). page_2k=1 selects 2KB.
- R2: The four-activate window, in cycles, is max(FAW_FLOOR_CK, ceil(ps / TCK_PS)). The ps value comes from the setting: 40000 (1KB) and 50000 (2KB) at speed_sel 0; 37500 and 50000 at speed_sel 1; 30000 and 45000 at speed_sel 2.
- R3: After an activate is reported in cycle t, act_grant is low in cycles t+1 to t+G-1 and may be high from cycle t+G, where G is the R1 gap.
- R4: While four activates are held in history, act_grant stays low until W cycles have passed since the oldest of them, where W is the R2 window.
- R5: After reset the history is empty, act_grant follows act_req at once, and the first four activates are limited only by the pairwise gap.
- R6: act_grant is never high while act_req is low.
- R7: violation rises in the cycle after an activate is reported while the guard forbids one. It then stays high until reset, and reset clears it to 0.
- R8: The limits follow the current page_2k and speed_sel values combinationally. Changing them re-evaluates the pending gap against the new limit in the same cycle.
- R9: speed_sel code 3 applies the same limits as code 2.
- R10: An activate reported while forbidden is still recorded, and the next gap counts from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_sel | input | 2 | Speed grade: 0=800, 1=1066, 2=1333, 3 same as 2 |
| page_2k | input | 1 | 1 selects 2KB page limits, 0 selects 1KB |
| act_req | input | 1 | Scheduler wants to activate this cycle (valid) |
| act_issued | input | 1 | An activate was driven this cycle |
| act_grant | output | 1 | Activate permitted this cycle (ready) |
| violation | output | 1 | Sticky: an activate was reported while forbidden |

## Verification
On every cycle the assertions check several invariants. The gap guard must block in the cycle after any reported activate. The violation flag must set on a forbidden activate and then hold. The history pointer must always address the oldest held activate. The selected window must never be shorter than the selected gap, and a grant must never appear without a request. Only the bench scenarios can show that each speed grade and page size produces the exact cycle counts, that the fifth activate opens exactly on the window boundary, and that the history after reset and after a select change behaves as specified.

// File: rtl/act_guard_pkg.sv
package act_guard_pkg;

  typedef enum logic [1:0] {
    SG_800  = 2'd0,
    SG_1066 = 2'd1,
    SG_1333 = 2'd2,
    SG_RSVD = 2'd3
  } speed_grade_e;

  // nanosecond minimums held in picoseconds
  localparam int RRD_1K_SLOW_PS = 7500;
  localparam int RRD_2K_SLOW_PS = 10000;
  localparam int RRD_1K_FAST_PS = 6000;
  localparam int RRD_2K_FAST_PS = 7500;
  localparam int WIN_1K_800_PS  = 40000;
  localparam int WIN_2K_800_PS  = 50000;
  localparam int WIN_1K_1066_PS = 37500;
  localparam int WIN_2K_1066_PS = 50000;
  localparam int WIN_1K_1333_PS = 30000;
  localparam int WIN_2K_1333_PS = 45000;

  function automatic int to_cycles(int ps, int tck_ps, int floor_ck);
    int c;
    c = (ps + tck_ps - 1) / tck_ps;
    return (c > floor_ck) ? c : floor_ck;
  endfunction

  function automatic int gap_ps(int grade, int big);
    if (grade >= 2) return (big != 0) ? RRD_2K_FAST_PS : RRD_1K_FAST_PS;
    return (big != 0) ? RRD_2K_SLOW_PS : RRD_1K_SLOW_PS;
  endfunction

  function automatic int win_ps(int grade, int big);
    case (grade)
      0:       return (big != 0) ? WIN_2K_800_PS  : WIN_1K_800_PS;
      1:       return (big != 0) ? WIN_2K_1066_PS : WIN_1K_1066_PS;
      default: return (big != 0) ? WIN_2K_1333_PS : WIN_1K_1333_PS;
    endcase
  endfunction

  function automatic int max_cycles(int tck_ps, int gap_floor, int win_floor);
    int m;
    m = 1;
    for (int g = 0; g < 4; g++) begin
      for (int p = 0; p < 2; p++) begin
        if (to_cycles(gap_ps(g, p), tck_ps, gap_floor) > m) m = to_cycles(gap_ps(g, p), tck_ps, gap_floor);
        if (to_cycles(win_ps(g, p), tck_ps, win_floor) > m) m = to_cycles(win_ps(g, p), tck_ps, win_floor);
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/act_limit_sel.sv
module act_limit_sel
  import act_guard_pkg::*;
#(
  parameter int TCK_PS       = 1500,
  parameter int GAP_FLOOR_CK = 4,
  parameter int WIN_FLOOR_CK = 4,
  parameter int CW           = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  speed_grade_e  grade,
  input  logic          page_2k,
  output logic [CW-1:0] gap_ck,
  output logic [CW-1:0] win_ck
);

  localparam int N_ENT = 8;

  logic [CW-1:0] gap_tab [N_ENT];
  logic [CW-1:0] win_tab [N_ENT];

  for (genvar g = 0; g < 4; g++) begin : g_grade
    for (genvar p = 0; p < 2; p++) begin : g_page
      localparam int GAP_C = to_cycles(gap_ps(g, p), TCK_PS, GAP_FLOOR_CK);
      localparam int WIN_C = to_cycles(win_ps(g, p), TCK_PS, WIN_FLOOR_CK);
      assign gap_tab[g*2+p] = CW'(GAP_C);
      assign win_tab[g*2+p] = CW'(WIN_C);
    end
  end

  logic [2:0] idx;
  assign idx    = {grade, page_2k};
  assign gap_ck = gap_tab[idx];
  assign win_ck = win_tab[idx];

  AST_WIN_COVERS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    win_ck >= gap_ck); // R2

endmodule

// File: rtl/act_gap_timer.sv
module act_gap_timer #(
  parameter int CW     = 6,
  parameter int MAX_CK = 34
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [CW-1:0] gap_ck,
  output logic          gap_ok
);

  logic [CW-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       since_q <= CW'(MAX_CK);
    else if (issue)                   since_q <= CW'(1);
    else if (since_q < CW'(MAX_CK))   since_q <= since_q + 1'b1;
  end

  assign gap_ok = (since_q >= gap_ck);

  // gap floor is at least two cycles, so the guard closes right after an issue
  AST_GAP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> !gap_ok); // R3

endmodule

// File: rtl/act_window_hist.sv
module act_window_hist #(
  parameter int DEPTH  = 4,
  parameter int CW     = 6,
  parameter int MAX_CK = 34
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [CW-1:0] win_ck,
  output logic          win_ok
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CW-1:0] age_q [DEPTH];
  logic          vld_q [DEPTH];
  logic [PW-1:0] wr_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          wr_ptr <= '0;
    else if (issue && wr_ptr == PW'(DEPTH-1)) wr_ptr <= '0;
    else if (issue)                      wr_ptr <= wr_ptr + 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        age_q[i] <= '0;
        vld_q[i] <= 1'b0;
      end else if (issue && wr_ptr == PW'(i)) begin
        age_q[i] <= CW'(1);
        vld_q[i] <= 1'b1;
      end else if (vld_q[i] && age_q[i] < CW'(MAX_CK)) begin
        age_q[i] <= age_q[i] + 1'b1;
      end
    end

    AST_OLDEST_AT_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q[i] && vld_q[wr_ptr]) |-> (age_q[wr_ptr] >= age_q[i])); // R4
  end

  // slot under the pointer is the oldest, or empty while history fills
  assign win_ok = !vld_q[wr_ptr] || (age_q[wr_ptr] >= win_ck);

endmodule

// File: rtl/act_spacing_guard.sv
module act_spacing_guard
  import act_guard_pkg::*;
#(
  parameter int TCK_PS       = 1500,
  parameter int GAP_FLOOR_CK = 4,
  parameter int WIN_FLOOR_CK = 4,
  parameter int WIN_COUNT    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] speed_sel,
  input  logic       page_2k,
  input  logic       act_req,
  input  logic       act_issued,
  output logic       act_grant,
  output logic       violation
);

  localparam int MAX_CK = max_cycles(TCK_PS, GAP_FLOOR_CK, WIN_FLOOR_CK);
  localparam int CW     = $clog2(MAX_CK + 1);

  logic [CW-1:0] gap_ck;
  logic [CW-1:0] win_ck;
  logic          gap_ok;
  logic          win_ok;
  logic          may_act;
  logic          viol_q;
  speed_grade_e  grade;

  assign grade = speed_grade_e'(speed_sel);

  act_limit_sel #(
    .TCK_PS(TCK_PS), .GAP_FLOOR_CK(GAP_FLOOR_CK),
    .WIN_FLOOR_CK(WIN_FLOOR_CK), .CW(CW)
  ) u_limits (
    .clk(clk), .rst_n(rst_n), .grade(grade), .page_2k(page_2k),
    .gap_ck(gap_ck), .win_ck(win_ck)
  );

  act_gap_timer #(.CW(CW), .MAX_CK(MAX_CK)) u_gap (
    .clk(clk), .rst_n(rst_n), .issue(act_issued),
    .gap_ck(gap_ck), .gap_ok(gap_ok)
  );

  act_window_hist #(.DEPTH(WIN_COUNT), .CW(CW), .MAX_CK(MAX_CK)) u_win (
    .clk(clk), .rst_n(rst_n), .issue(act_issued),
    .win_ck(win_ck), .win_ok(win_ok)
  );

  assign may_act   = gap_ok && win_ok;
  assign act_grant = act_req && may_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      viol_q <= 1'b0;
    else if (act_issued && !may_act) viol_q <= 1'b1;
  end

  assign violation = viol_q;

  AST_VIOL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (act_issued && !gap_ok) |=> violation); // R7

  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> violation); // R7

  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    act_grant |-> act_req); // R6

endmodule

// File: tb/act_spacing_guard_tb_top.sv
module act_spacing_guard_tb_top;

  localparam int TCK = 1500;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] speed_sel = 2'd0;
  logic       page_2k = 1'b0;
  logic       act_req = 1'b0;
  logic       act_issued = 1'b0;
  logic       act_grant;
  logic       violation;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk; // 250 MHz

  act_spacing_guard #(.TCK_PS(TCK)) dut_i (
    .clk(clk), .rst_n(rst_n), .speed_sel(speed_sel), .page_2k(page_2k),
    .act_req(act_req), .act_issued(act_issued),
    .act_grant(act_grant), .violation(violation)
  );

  function automatic int ceil_ck(int ps);
    int c;
    c = (ps + TCK - 1) / TCK;
    return (c < 4) ? 4 : c;
  endfunction

  function automatic int exp_gap(int sg, int pg);
    if (sg >= 2) return ceil_ck(pg ? 7500 : 6000);
    return ceil_ck(pg ? 10000 : 7500);
  endfunction

  function automatic int exp_win(int sg, int pg);
    if (sg == 0) return ceil_ck(pg ? 50000 : 40000);
    if (sg == 1) return ceil_ck(pg ? 50000 : 37500);
    return ceil_ck(pg ? 45000 : 30000);
  endfunction

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    act_issued = 1'b0;
    act_req    = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // issue one activate; returns in cycle 1 after it
  task automatic pulse();
    act_issued = 1'b1;
    @(negedge clk);
    act_issued = 1'b0;
  endtask

  task automatic t_reset_state();
    speed_sel = 2'd0; page_2k = 1'b0;
    do_reset();
    chk(act_grant, 1'b1, "R5", "grant after reset");
    chk(violation, 1'b0, "R7", "violation after reset");
    act_req = 1'b0;
    #1;
    chk(act_grant, 1'b0, "R6", "no grant without request");
    act_req = 1'b1;
  endtask

  task automatic t_gap(input int sg, input int pg, input string req);
    int g;
    speed_sel = 2'(sg); page_2k = 1'(pg);
    do_reset();
    g = exp_gap(sg, pg);
    pulse();
    repeat (g - 2) @(negedge clk);
    chk(act_grant, 1'b0, req, $sformatf("gap sg%0d pg%0d closed at G-1", sg, pg));
    @(negedge clk);
    chk(act_grant, 1'b1, req, $sformatf("gap sg%0d pg%0d open at G", sg, pg));
  endtask

  task automatic t_window(input int sg, input int pg);
    int g;
    int w;
    speed_sel = 2'(sg); page_2k = 1'(pg);
    do_reset();
    g = exp_gap(sg, pg);
    w = exp_win(sg, pg);
    for (int k = 0; k < 4; k++) begin
      if (k > 0) repeat (g - 1) @(negedge clk);
      chk(act_grant, 1'b1, "R5", $sformatf("activate %0d granted sg%0d pg%0d", k, sg, pg));
      pulse();
    end
    repeat ((w - 1) - (3 * g + 1)) @(negedge clk);
    chk(act_grant, 1'b0, "R4", $sformatf("fifth blocked at W-1 sg%0d pg%0d", sg, pg));
    @(negedge clk);
    chk(act_grant, 1'b1, "R2", $sformatf("fifth open at W sg%0d pg%0d", sg, pg));
    chk(violation, 1'b0, "R7", "no violation on legal stream");
  endtask

  task automatic t_violation();
    int g;
    speed_sel = 2'd0; page_2k = 1'b0;
    do_reset();
    g = exp_gap(0, 0);
    pulse();
    pulse(); // forbidden, one cycle after the first
    chk(violation, 1'b1, "R7", "violation set");
    repeat (g - 2) @(negedge clk);
    chk(act_grant, 1'b0, "R10", "gap counts from forbidden activate");
    @(negedge clk);
    chk(act_grant, 1'b1, "R10", "gap reopens after forbidden activate");
    repeat (40) @(negedge clk);
    chk(violation, 1'b1, "R7", "violation sticky");
    do_reset();
    chk(violation, 1'b0, "R7", "reset clears violation");
  endtask

  task automatic t_sel_change();
    speed_sel = 2'd0; page_2k = 1'b1; // gap 7
    do_reset();
    pulse();
    repeat (3) @(negedge clk); // cycle 4
    chk(act_grant, 1'b0, "R8", "closed under long gap");
    speed_sel = 2'd2; page_2k = 1'b0; // gap 4
    #1;
    chk(act_grant, 1'b1, "R8", "open at once under short gap");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset_state();
    for (int sg = 0; sg < 3; sg++) begin
      for (int pg = 0; pg < 2; pg++) begin
        t_gap(sg, pg, "R1");
        t_window(sg, pg);
      end
    end
    t_gap(3, 0, "R9");
    t_gap(3, 1, "R9");
    t_gap(1, 1, "R3");
    t_violation();
    t_sel_change();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule